// File: doc/BRIEF.md
# Best-Match Associative Memory

This block holds a small table of binary words in registers and, on request, finds the stored word closest to a presented sample. Closeness is Hamming similarity: for every entry the block counts the bit positions where entry and sample agree, all entries in parallel, and then selects the entry with the highest agreement count. It answers "which stored pattern is nearest", not "is there an exact hit".

Selection is a timed race instead of a comparator tree. A shared reference level starts at the word width and drops by one each clock. On the first cycle that any entry's count reaches the level, the block freezes that entry as the single winner and ignores all later crossings. Ties at the same level go to the lowest entry number. The result is a one-hot winner vector, its encoded index and its count, together with a one-cycle completion strobe. The values hold until the next search begins.

Entries are loaded through a plain write port. While a race is running, the block drops writes and further search requests, so every result matches the table as it stood when the search began.

Top module: `bm_assoc_top`

## Requirements
- R1: After reset every stored entry reads as all zeros, `done` is 0, `win_onehot` is all zeros, and `win_idx` and `win_count` are 0.
- R2: A cycle with `wr_en` high while no search is running stores `wr_data` into the entry numbered `wr_addr`, and later searches compare against that value.
- R3: An entry's score is the number of bit positions where the entry equals `sample` (the popcount of their XNOR). When `done` is high, `win_count` reports the winner's score, which lies between 0 and WIDTH.
- R4: The winner is an entry whose score is the largest of all entries, and `win_idx` gives its entry number.
- R5: If several entries share the largest score, the one with the lowest entry number wins.
- R6: When `done` is high, `win_onehot` has exactly one bit set, at bit position `win_idx`. From the cycle after a search is accepted until `done`, `win_onehot` is all zeros.
- R7: With the best score m, `done` rises (WIDTH − m + 1) clock edges after the edge that accepts `search_start`. So a search never takes more than WIDTH+1 cycles, and an exact match takes 1 cycle.
- R8: `done` stays high for exactly one cycle. `win_idx`, `win_count` and `win_onehot` then hold their values until the next accepted search.
- R9: Writes and `search_start` pulses that arrive while a search is running are ignored. The table stays as it was and no additional result is produced.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the entry table |
| wr_addr | input | IDX_W | Entry number to write |
| wr_data | input | WIDTH | Word to store |
| search_start | input | 1 | Begins a search when the block is idle |
| sample | input | WIDTH | Word to search for, sampled with `search_start` |
| done | output | 1 | One-cycle completion strobe |
| win_onehot | output | ENTRIES | One-hot winner vector |
| win_idx | output | IDX_W | Encoded winner entry number |
| win_count | output | CNT_W | Number of agreeing bits in the winner |

## Verification
The searches cover several cases: an all-zero table, where every entry ties and the lowest number must win; a single planted exact match, which checks the one-cycle latency; a sample one bit away from the planted word; and its bitwise complement, which loses and lets the untouched entries tie. A table filled with one word and searched with its inverse drives every score to zero and gives the longest race. A table filled with scattered pseudo-random words varies both the winner position and the latency. Writes and extra start pulses sent in the middle of a race are then followed by a search that would reveal any corruption.

// File: rtl/bm_assoc_pkg.sv
package bm_assoc_pkg;
  typedef enum logic [0:0] {
    RACE_IDLE = 1'b0,
    RACE_RUN  = 1'b1
  } race_state_e;
endpackage

// File: rtl/bm_store.sv
module bm_store #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 16,
  parameter int IDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IDX_W-1:0]           waddr,
  input  logic [WIDTH-1:0]           wdata,
  output logic [ENTRIES*WIDTH-1:0]   flat
);
  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < ENTRIES)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign flat[g*WIDTH +: WIDTH] = mem[g];
  end
endmodule

// File: rtl/bm_scorer.sv
module bm_scorer #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 16,
  parameter int CNT_W   = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load,
  input  logic [ENTRIES*WIDTH-1:0]        flat,
  input  logic [WIDTH-1:0]                sample,
  output logic [ENTRIES-1:0][CNT_W-1:0]   score
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_lane
    logic [WIDTH-1:0] agree;
    logic [CNT_W-1:0] tally;
    logic [CNT_W-1:0] score_q;

    assign agree = ~(flat[g*WIDTH +: WIDTH] ^ sample);

    always_comb begin
      tally = '0;
      for (int b = 0; b < WIDTH; b++) tally = tally + CNT_W'(agree[b]);
    end

    always_ff @(posedge clk) begin
      if (rst)       score_q <= '0;
      else if (load) score_q <= tally;
    end

    assign score[g] = score_q;
  end
endmodule

// File: rtl/bm_wta.sv
module bm_wta
  import bm_assoc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 16,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load,
  input  logic [ENTRIES-1:0][CNT_W-1:0]   score,
  output logic                            busy,
  output logic                            done,
  output logic [ENTRIES-1:0]              onehot,
  output logic [IDX_W-1:0]                idx,
  output logic [CNT_W-1:0]                count
);
  race_state_e       state;
  logic [CNT_W-1:0]  level;
  logic [ENTRIES-1:0] crossed;
  logic [ENTRIES-1:0] first;
  logic [IDX_W-1:0]  pick;
  logic              any_cross;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) crossed[i] = (score[i] >= level);
    first     = crossed & (~crossed + ENTRIES'(1));
    any_cross = |crossed;
    pick      = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (crossed[i]) pick = IDX_W'(i);
    end
  end

  assign busy = (state == RACE_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RACE_IDLE;
      level  <= '0;
      done   <= 1'b0;
      onehot <= '0;
      idx    <= '0;
      count  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        RACE_IDLE: begin
          if (load) begin
            state  <= RACE_RUN;
            level  <= CNT_W'(WIDTH);
            onehot <= '0;
            idx    <= '0;
            count  <= '0;
          end
        end
        RACE_RUN: begin
          if (any_cross) begin
            onehot <= first;
            idx    <= pick;
            count  <= score[pick];
            done   <= 1'b1;
            state  <= RACE_IDLE;
          end else begin
            level <= level - CNT_W'(1);
          end
        end
        default: state <= RACE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bm_assoc_top.sv
module bm_assoc_top #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 16,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  parameter int CNT_W   = $clog2(WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_addr,
  input  logic [WIDTH-1:0]     wr_data,
  input  logic                 search_start,
  input  logic [WIDTH-1:0]     sample,
  output logic                 done,
  output logic [ENTRIES-1:0]   win_onehot,
  output logic [IDX_W-1:0]     win_idx,
  output logic [CNT_W-1:0]     win_count
);
  logic [ENTRIES*WIDTH-1:0]      store_flat;
  logic [ENTRIES-1:0][CNT_W-1:0] scores;
  logic                          race_busy;
  logic                          accept;
  logic                          store_we;

  assign accept   = search_start & ~race_busy;
  assign store_we = wr_en & ~race_busy;

  bm_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .we(store_we), .waddr(wr_addr), .wdata(wr_data),
    .flat(store_flat)
  );

  bm_scorer #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_scorer (
    .clk(clk), .rst(rst), .load(accept), .flat(store_flat), .sample(sample),
    .score(scores)
  );

  bm_wta #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_wta (
    .clk(clk), .rst(rst), .load(accept), .score(scores), .busy(race_busy),
    .done(done), .onehot(win_onehot), .idx(win_idx), .count(win_count)
  );
endmodule

// File: rtl/bm_assoc_chk.sv
module bm_assoc_chk #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 16,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 5
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic                       search_start,
  input logic                       race_busy,
  input logic                       done,
  input logic [ENTRIES-1:0]         win_onehot,
  input logic [IDX_W-1:0]           win_idx,
  input logic [CNT_W-1:0]           win_count,
  input logic [ENTRIES*WIDTH-1:0]   store_flat
);
  logic [CNT_W:0] race_len;

  always_ff @(posedge clk) begin
    if (rst || !race_busy) race_len <= '0;
    else                   race_len <= race_len + 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && win_onehot == '0 && store_flat == '0));

  a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(win_count) <= WIDTH));

  a_r6_single_winner: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones(win_onehot) == 1 && win_onehot[win_idx]));

  a_r6_clear_in_race: assert property (@(posedge clk) disable iff (rst)
    (race_busy && !done) |-> (win_onehot == '0));

  a_r7_race_bound: assert property (@(posedge clk) disable iff (rst)
    int'(race_len) <= WIDTH + 1);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
    (!race_busy && !search_start && !done) |=>
      ($stable(win_idx) && $stable(win_count) && $stable(win_onehot)));

  a_r9_no_write_in_race: assert property (@(posedge clk) disable iff (rst)
    (race_busy && wr_en) |=> $stable(store_flat));
endmodule

bind bm_assoc_top bm_assoc_chk #(
  .ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .search_start(search_start),
  .race_busy(race_busy), .done(done), .win_onehot(win_onehot),
  .win_idx(win_idx), .win_count(win_count), .store_flat(store_flat)
);

// File: tb/sim_bm_assoc_top.sv
`timescale 1ns/1ps
module sim_bm_assoc_top;
  localparam int ENTRIES = 16;
  localparam int WIDTH   = 16;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int CNT_W   = $clog2(WIDTH + 1);

  typedef struct {
    int idx;
    int count;
    int due;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic search_start = 1'b0;
  logic [WIDTH-1:0] sample = '0;
  logic done;
  logic [ENTRIES-1:0] win_onehot;
  logic [IDX_W-1:0] win_idx;
  logic [CNT_W-1:0] win_count;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [WIDTH-1:0] shadow [ENTRIES];
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bm_assoc_top #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .search_start(search_start), .sample(sample), .done(done),
    .win_onehot(win_onehot), .win_idx(win_idx), .win_count(win_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops an expected result each time done is seen
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(win_idx) == e.idx, {e.tag, " R4 R5 index"}, int'(win_idx), e.idx);
        check(int'(win_count) == e.count, {e.tag, " R3 count"}, int'(win_count), e.count);
        check(win_onehot == (ENTRIES'(1) << e.idx), {e.tag, " R6 onehot"},
              int'(win_onehot), 1 << e.idx);
        check(cyc == e.due, {e.tag, " R7 latency"}, cyc, e.due);
      end
    end
  end

  task automatic write_entry(input int a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = IDX_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[a] = d; // R2
  endtask

  task automatic search(input logic [WIDTH-1:0] s, input string tag);
    exp_t e;
    int best;
    int bi;
    best = -1; bi = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      int sc;
      sc = $countones(~(shadow[i] ^ s));
      if (sc > best) begin best = sc; bi = i; end
    end
    @(negedge clk);
    e.idx = bi; e.count = best; e.due = cyc + WIDTH - best + 2; e.tag = tag;
    q.push_back(e);
    search_start = 1'b1; sample = s;
    @(negedge clk);
    search_start = 1'b0;
    if (best < WIDTH) check(win_onehot == '0, {tag, " R6 cleared during race"},
                            int'(win_onehot), 0);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] lfsr;
    int hold_idx;
    int hold_cnt;
    for (int i = 0; i < ENTRIES; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(win_onehot == '0, "R1 onehot", int'(win_onehot), 0);
    check(win_idx == '0 && win_count == '0, "R1 idx/count", int'(win_count), 0);

    // R1 R5 R10: zero table, all tie at full width
    search('0, "zero-table");
    // R2 planted exact match -> latency 1 (R7)
    write_entry(5, 16'hA5A5);
    search(16'hA5A5, "exact");
    search(16'hA5A4, "one-off");
    search(16'h5A5A, "complement");

    // R8 hold: results stay after done
    hold_idx = int'(win_idx); hold_cnt = int'(win_count);
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", int'(done), 0);
    check(int'(win_idx) == hold_idx && int'(win_count) == hold_cnt,
          "R8 hold idx", int'(win_idx), hold_idx);

    // R7 longest race: every score zero
    for (int i = 0; i < ENTRIES; i++) write_entry(i, 16'h0F0F);
    search(16'hF0F0, "all-zero-score");

    // Scattered table
    lfsr = 16'hACE1;
    for (int i = 0; i < ENTRIES; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      write_entry(i, lfsr ^ 16'(i * 16'h0111));
    end
    for (int k = 0; k < 6; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      search(lfsr, "scatter");
    end
    search(shadow[11], "scatter-exact");

    // R9: write and extra start during a race are ignored
    begin
      exp_t e;
      int best;
      int bi;
      best = -1; bi = 0;
      for (int i = 0; i < ENTRIES; i++) begin
        int sc;
        sc = $countones(~(shadow[i] ^ 16'h0000));
        if (sc > best) begin best = sc; bi = i; end
      end
      @(negedge clk);
      e.idx = bi; e.count = best; e.due = cyc + WIDTH - best + 2; e.tag = "mid-race";
      q.push_back(e);
      search_start = 1'b1; sample = '0;
      @(negedge clk);
      search_start = 1'b1; sample = 16'hFFFF;
      wr_en = 1'b1; wr_addr = IDX_W'(3); wr_data = 16'h0000;
      @(negedge clk);
      search_start = 1'b0; wr_en = 1'b0;
      while (q.size() != 0) @(negedge clk);
      repeat (WIDTH + 3) @(negedge clk);
    end
    // entry 3 unchanged: search for 0 again must match shadow
    search(16'h0000, "R9 after ignored write");
    search(shadow[3], "R9 entry3 intact");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule